// File: doc/BRIEF.md
# Memory Controller Event Counter Bank

This block holds a small bank of event counters that watch a memory controller. Slot 0 counts clock cycles and also acts as the run switch for the whole bank. Slots 1 and up count an event picked by an 8-bit code. The codes are generic pulse lines, read beats or write beats. A beat is counted only when its transaction ID matches under a mask, its port number matches, and its channel bit matches the programmed value.

Software programs the bank through a flat register bus with a write strobe and a read port that is always available. Each slot has a control word that holds enable, clear, a sticky overflow flag, an 8-bit preload and the event code. Slot 0 overflowing freezes every slot and raises the single interrupt line. When any other slot overflows, only that slot parks, and it does so without an interrupt. Software drains the counts, clears the flag and lets the bank run again.

Top module: `mc_perf_bank`

## Requirements
- R1: After reset every control word, every count and the interrupt read as zero.
- R2: A write to slot n's control word at byte address 4·n stores enable (bit 2), preload (bits 23:16) and event code (bits 31:24), and these read back in place. Bit 1 set in that write loads the preload into the top 8 bits of the count, zeroes the lower count bits and clears the overflow flag. The count reads at 0x20 + 4·n, zero-extended to 32 bits.
- R3: While slot 0 is enabled and its overflow flag is clear, its count rises by exactly one per clock.
- R4: While slot 0 is disabled, no other slot's count changes, whatever events arrive.
- R5: When slot 0 steps past its all-ones value, it wraps to zero and sets bit 0 of its control word, and the interrupt goes high. From then on no count in the bank changes until software writes a control word.
- R6: When slot n ≥ 1 steps past all-ones, it wraps to zero, sets its own bit 0 and stops counting. The interrupt stays low and the other slots keep counting.
- R7: A write to slot 0's control word with bit 0 or bit 1 set clears its overflow flag and drops the interrupt on the next clock. With enable set, counting resumes from the following clock.
- R8: Event codes 0x01 to NUM_GEN count clocks in which the generic line (code − 1) is high. Any other code that is not 0x41 or 0x42 counts nothing on slots 1 and up.
- R9: Code 0x41 counts read beats. The slot's filter word at 0x54 + 16·(n−1) holds an ID in bits 15:0 and an inverted mask in bits 31:16. ID bits whose stored mask bit is 1 are ignored. The selector word at 0x50 + 16·(n−1) must match the beat port in bits 2:0. The beat channel must equal the inverse of bit 3.
- R10: Code 0x42 counts write beats under the same ID rule. The port is taken from bits 10:8 of the selector word, and the channel must equal the inverse of bit 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | ADDR_W | Byte address for reads and writes |
| reg_wen_i | input | 1 | Write strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, combinational |
| evt_i | input | NUM_GEN | Generic event lines, one count per high clock |
| rd_beat_i | input | 1 | Read beat valid |
| rd_id_i | input | 16 | Read beat transaction ID |
| rd_port_i | input | 3 | Read beat port |
| rd_chan_i | input | 1 | Read beat channel |
| wr_beat_i | input | 1 | Write beat valid |
| wr_id_i | input | 16 | Write beat transaction ID |
| wr_port_i | input | 3 | Write beat port |
| wr_chan_i | input | 1 | Write beat channel |
| irq_o | output | 1 | High while slot 0's overflow flag is set |

## Verification
The assertions assume that register writes only reach the block through the strobe. They also assume that no event input can change a count unless slot 0 is running. The bench keeps every write on a clean clock with the strobe held for one cycle, and it changes events and beats only between edges. The bench runs with narrow counters so that wraps on slot 0 and on the other slots both happen within the run. The beat patterns are chosen to miss the filter on exactly one term at a time: the masked ID, the port, or the channel.

// File: rtl/mcp_pkg.sv
package mcp_pkg;
   localparam int AXI_ID_W = 16;
   localparam int PORT_W   = 3;

   localparam logic [7:0] EVT_CYCLES  = 8'h00;
   localparam logic [7:0] EVT_RD_BEAT = 8'h41;
   localparam logic [7:0] EVT_WR_BEAT = 8'h42;

   // control word layout
   localparam int CTL_OVF     = 0;
   localparam int CTL_CLR     = 1;
   localparam int CTL_EN      = 2;
   localparam int CTL_PRE_LSB = 16;
   localparam int CTL_SEL_LSB = 24;

   // selector word layout (channel bits stored inverted)
   localparam int SEL_RPORT_LSB = 0;
   localparam int SEL_RCHAN_N   = 3;
   localparam int SEL_WPORT_LSB = 8;
   localparam int SEL_WCHAN_N   = 11;

   // address map
   localparam int CNT_BASE    = 'h20;
   localparam int SELW_BASE   = 'h50;
   localparam int FLTW_BASE   = 'h54;
   localparam int SLOT_STRIDE = 16;

   typedef struct packed {
      logic                vld;
      logic [AXI_ID_W-1:0] id;
      logic [PORT_W-1:0]   port;
      logic                chan;
   } beat_t;
endpackage

// File: rtl/mcp_beat_filter.sv
module mcp_beat_filter
   import mcp_pkg::*;
(
   input  beat_t               beat_i,
   input  logic [AXI_ID_W-1:0] fid_i,
   input  logic [AXI_ID_W-1:0] fmask_n_i,
   input  logic [PORT_W-1:0]   fport_i,
   input  logic                fchan_n_i,
   output logic                match_o
);
   logic id_ok, port_ok, chan_ok;

   assign id_ok   = ((beat_i.id & ~fmask_n_i) == (fid_i & ~fmask_n_i));
   assign port_ok = (beat_i.port == fport_i);
   assign chan_ok = (beat_i.chan == ~fchan_n_i);
   assign match_o = beat_i.vld & id_ok & port_ok & chan_ok;
endmodule

// File: rtl/mcp_counter_slice.sv
module mcp_counter_slice
   import mcp_pkg::*;
#(
   parameter int CNT_W    = 32,
   parameter int NUM_GEN  = 8,
   parameter bit IS_CYCLE = 1'b0
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               run_i,
   input  logic               wr_ctrl_i,
   input  logic               wr_flt_i,
   input  logic               wr_sel_i,
   input  logic [31:0]        wdata_i,
   input  logic [NUM_GEN-1:0] evt_i,
   input  beat_t              rd_beat_i,
   input  beat_t              wr_beat_i,
   output logic [31:0]        ctrl_o,
   output logic [CNT_W-1:0]   cnt_o,
   output logic [31:0]        flt_o,
   output logic [31:0]        selw_o,
   output logic               en_o,
   output logic               ovf_o
);
   localparam int LOW_W = CNT_W - 8;

   if (CNT_W < 9 || CNT_W > 32) begin : g_bad_width
      $error("mcp_counter_slice: CNT_W must be 9..32");
   end

   logic             en_q, ovf_q;
   logic [7:0]       pre_q, sel_q;
   logic [CNT_W-1:0] cnt_q;
   logic             inc, clr_w, at_max;

   assign clr_w  = wr_ctrl_i & wdata_i[CTL_CLR];
   assign at_max = &cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_q  <= 1'b0;
         ovf_q <= 1'b0;
         pre_q <= '0;
         sel_q <= '0;
         cnt_q <= '0;
      end else begin
         if (clr_w)    cnt_q <= {wdata_i[CTL_PRE_LSB +: 8], {LOW_W{1'b0}}};
         else if (inc) cnt_q <= cnt_q + 1'b1;

         if (clr_w)                                ovf_q <= 1'b0;
         else if (inc && at_max)                   ovf_q <= 1'b1;
         else if (wr_ctrl_i && wdata_i[CTL_OVF])   ovf_q <= 1'b0;

         if (wr_ctrl_i) begin
            en_q  <= wdata_i[CTL_EN];
            pre_q <= wdata_i[CTL_PRE_LSB +: 8];
            sel_q <= wdata_i[CTL_SEL_LSB +: 8];
         end
      end
   end

   assign ctrl_o = {sel_q, pre_q, 13'b0, en_q, 1'b0, ovf_q};
   assign cnt_o  = cnt_q;
   assign en_o   = en_q;
   assign ovf_o  = ovf_q;

   if (IS_CYCLE) begin : g_cycle
      assign inc    = run_i;
      assign flt_o  = '0;
      assign selw_o = '0;
      logic unused_cyc;
      assign unused_cyc = ^{wr_flt_i, wr_sel_i, wdata_i[15:3], evt_i,
                            rd_beat_i, wr_beat_i};

      // R3
      cycle_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (run_i && !wr_ctrl_i) |=> (cnt_q == $past(cnt_q) + 1'b1));
   end else begin : g_event
      logic [31:0] flt_q, selw_q;
      logic        rd_hit, wr_hit, gen_hit, hit;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            flt_q  <= '0;
            selw_q <= '0;
         end else begin
            if (wr_flt_i) flt_q  <= wdata_i;
            if (wr_sel_i) selw_q <= wdata_i;
         end
      end

      mcp_beat_filter u_rd_flt (
         .beat_i    (rd_beat_i),
         .fid_i     (flt_q[15:0]),
         .fmask_n_i (flt_q[31:16]),
         .fport_i   (selw_q[SEL_RPORT_LSB +: PORT_W]),
         .fchan_n_i (selw_q[SEL_RCHAN_N]),
         .match_o   (rd_hit)
      );

      mcp_beat_filter u_wr_flt (
         .beat_i    (wr_beat_i),
         .fid_i     (flt_q[15:0]),
         .fmask_n_i (flt_q[31:16]),
         .fport_i   (selw_q[SEL_WPORT_LSB +: PORT_W]),
         .fchan_n_i (selw_q[SEL_WCHAN_N]),
         .match_o   (wr_hit)
      );

      always_comb begin
         gen_hit = 1'b0;
         for (int g = 0; g < NUM_GEN; g++) begin
            if (sel_q == 8'(g + 1)) gen_hit = evt_i[g];
         end
      end

      assign hit    = (sel_q == EVT_RD_BEAT) ? rd_hit :
                      (sel_q == EVT_WR_BEAT) ? wr_hit : gen_hit;
      assign inc    = run_i & en_q & ~ovf_q & hit;
      assign flt_o  = flt_q;
      assign selw_o = selw_q;

      // R6
      slot_park_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (ovf_q && !wr_ctrl_i) |=> (ovf_q && $stable(cnt_q)));
   end

   // R5
   ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ovf_q && !wr_ctrl_i) |=> ovf_q);
endmodule

// File: rtl/mc_perf_bank.sv
module mc_perf_bank
   import mcp_pkg::*;
#(
   parameter int NUM_CNT = 4,
   parameter int CNT_W   = 32,
   parameter int NUM_GEN = 8,
   parameter int ADDR_W  = 8
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic [ADDR_W-1:0]   reg_addr_i,
   input  logic                reg_wen_i,
   input  logic [31:0]         reg_wdata_i,
   output logic [31:0]         reg_rdata_o,
   input  logic [NUM_GEN-1:0]  evt_i,
   input  logic                rd_beat_i,
   input  logic [AXI_ID_W-1:0] rd_id_i,
   input  logic [PORT_W-1:0]   rd_port_i,
   input  logic                rd_chan_i,
   input  logic                wr_beat_i,
   input  logic [AXI_ID_W-1:0] wr_id_i,
   input  logic [PORT_W-1:0]   wr_port_i,
   input  logic                wr_chan_i,
   output logic                irq_o
);
   localparam int TOP_ADDR = FLTW_BASE + SLOT_STRIDE * (NUM_CNT - 2);

   if (NUM_CNT < 2 || NUM_CNT > 8) begin : g_bad_cnt
      $error("mc_perf_bank: NUM_CNT must be 2..8");
   end
   if (NUM_GEN < 1 || NUM_GEN > 64) begin : g_bad_gen
      $error("mc_perf_bank: NUM_GEN must be 1..64");
   end
   if (TOP_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("mc_perf_bank: ADDR_W too narrow for the map");
   end

   beat_t rd_beat, wr_beat;
   assign rd_beat = '{vld: rd_beat_i, id: rd_id_i, port: rd_port_i, chan: rd_chan_i};
   assign wr_beat = '{vld: wr_beat_i, id: wr_id_i, port: wr_port_i, chan: wr_chan_i};

   logic [NUM_CNT-1:0]            wr_ctrl, wr_flt, wr_sel, en_w, ovf_w;
   logic [NUM_CNT-1:0][31:0]      ctrl_w, flt_w, selw_w;
   logic [NUM_CNT-1:0][CNT_W-1:0] cnt_w;
   logic                          run;

   assign run   = en_w[0] & ~ovf_w[0];
   assign irq_o = ovf_w[0];

   for (genvar n = 0; n < NUM_CNT; n++) begin : g_slot
      assign wr_ctrl[n] = reg_wen_i && (reg_addr_i == ADDR_W'(4 * n));
      if (n == 0) begin : g_nofilt
         assign wr_flt[n] = 1'b0;
         assign wr_sel[n] = 1'b0;
      end else begin : g_filt
         assign wr_sel[n] = reg_wen_i &&
            (reg_addr_i == ADDR_W'(SELW_BASE + SLOT_STRIDE * (n - 1)));
         assign wr_flt[n] = reg_wen_i &&
            (reg_addr_i == ADDR_W'(FLTW_BASE + SLOT_STRIDE * (n - 1)));
      end

      mcp_counter_slice #(
         .CNT_W    (CNT_W),
         .NUM_GEN  (NUM_GEN),
         .IS_CYCLE (n == 0)
      ) u_slice (
         .clk_i     (clk_i),
         .rst_ni    (rst_ni),
         .run_i     (run),
         .wr_ctrl_i (wr_ctrl[n]),
         .wr_flt_i  (wr_flt[n]),
         .wr_sel_i  (wr_sel[n]),
         .wdata_i   (reg_wdata_i),
         .evt_i     (evt_i),
         .rd_beat_i (rd_beat),
         .wr_beat_i (wr_beat),
         .ctrl_o    (ctrl_w[n]),
         .cnt_o     (cnt_w[n]),
         .flt_o     (flt_w[n]),
         .selw_o    (selw_w[n]),
         .en_o      (en_w[n]),
         .ovf_o     (ovf_w[n])
      );
   end

   always_comb begin
      reg_rdata_o = '0;
      for (int n = 0; n < NUM_CNT; n++) begin
         if (reg_addr_i == ADDR_W'(4 * n))            reg_rdata_o = ctrl_w[n];
         if (reg_addr_i == ADDR_W'(CNT_BASE + 4 * n)) reg_rdata_o = 32'(cnt_w[n]);
         if (n > 0) begin
            if (reg_addr_i == ADDR_W'(SELW_BASE + SLOT_STRIDE * (n - 1)))
               reg_rdata_o = selw_w[n];
            if (reg_addr_i == ADDR_W'(FLTW_BASE + SLOT_STRIDE * (n - 1)))
               reg_rdata_o = flt_w[n];
         end
      end
   end

   // R5
   bank_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_o && !(|wr_ctrl)) |=> $stable(cnt_w));

   // R4
   bank_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!en_w[0] && !(|wr_ctrl)) |=> $stable(cnt_w));

   // R7
   irq_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_ctrl[0] && (reg_wdata_i[CTL_OVF] || reg_wdata_i[CTL_CLR])) |=> !irq_o);

   // R6
   irq_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(irq_o) |-> $past(run));
endmodule

// File: tb/mc_perf_bank_tb.sv
module mc_perf_bank_tb;
   localparam int CLK_PERIOD = 60;
   localparam int CW   = 12;
   localparam int NC   = 4;
   localparam int NG   = 8;
   localparam int CMAX = (1 << CW) - 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic        reg_wen = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [NG-1:0] evt = '0;
   logic        rd_beat = 0, wr_beat = 0, rd_chan = 0, wr_chan = 0;
   logic [15:0] rd_id = '0, wr_id = '0;
   logic [2:0]  rd_port = '0, wr_port = '0;
   logic        irq;

   int checks = 0;
   int errors = 0;
   string cur_req = "R1";

   always #(CLK_PERIOD / 2) clk = ~clk;

   mc_perf_bank #(.NUM_CNT(NC), .CNT_W(CW), .NUM_GEN(NG), .ADDR_W(8)) u_dut (
      .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(reg_addr), .reg_wen_i(reg_wen),
      .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .evt_i(evt),
      .rd_beat_i(rd_beat), .rd_id_i(rd_id), .rd_port_i(rd_port), .rd_chan_i(rd_chan),
      .wr_beat_i(wr_beat), .wr_id_i(wr_id), .wr_port_i(wr_port), .wr_chan_i(wr_chan),
      .irq_o(irq)
   );

   // behavioural reference state
   int unsigned m_cnt [NC];
   bit          m_en  [NC];
   bit          m_ovf [NC];
   bit [7:0]    m_pre [NC];
   bit [7:0]    m_sel [NC];
   bit [31:0]   m_flt [NC];
   bit [31:0]   m_selw[NC];

   task automatic chk(input string req, input string what, input longint got, input longint exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, got, exp);
      end
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] v);
      logic [7:0] save;
      save = reg_addr;
      reg_addr = a;
      #1;
      v = reg_rdata;
      reg_addr = save;
   endtask

   function automatic bit m_hit(input int n);
      bit [15:0] msk;
      msk = m_flt[n][31:16];
      if (m_sel[n] == 8'h41)
         return rd_beat && ((rd_id & ~msk) == (m_flt[n][15:0] & ~msk)) &&
                (rd_port == m_selw[n][2:0]) && (rd_chan == !m_selw[n][3]);
      if (m_sel[n] == 8'h42)
         return wr_beat && ((wr_id & ~msk) == (m_flt[n][15:0] & ~msk)) &&
                (wr_port == m_selw[n][10:8]) && (wr_chan == !m_selw[n][11]);
      if (m_sel[n] >= 1 && m_sel[n] <= NG) return evt[m_sel[n] - 1];
      return 1'b0;
   endfunction

   task automatic model_step();
      bit run;
      run = m_en[0] && !m_ovf[0];
      for (int n = 0; n < NC; n++) begin
         bit wrc, inc, wrapped;
         wrc = reg_wen && (reg_addr == 8'(4 * n));
         inc = (n == 0) ? run : (run && m_en[n] && !m_ovf[n] && m_hit(n));
         wrapped = 0;
         if (wrc && reg_wdata[1]) begin
            m_cnt[n] = int'(reg_wdata[23:16]) << (CW - 8);
            m_ovf[n] = 0;
         end else begin
            if (inc) begin
               if (m_cnt[n] == CMAX) begin
                  m_cnt[n] = 0; m_ovf[n] = 1; wrapped = 1;
               end else m_cnt[n]++;
            end
            if (!wrapped && wrc && reg_wdata[0]) m_ovf[n] = 0;
         end
         if (wrc) begin
            m_en[n]  = reg_wdata[2];
            m_pre[n] = reg_wdata[23:16];
            m_sel[n] = reg_wdata[31:24];
         end
         if (n > 0 && reg_wen && reg_addr == 8'('h50 + 16 * (n - 1))) m_selw[n] = reg_wdata;
         if (n > 0 && reg_wen && reg_addr == 8'('h54 + 16 * (n - 1))) m_flt[n]  = reg_wdata;
      end
   endtask

   task automatic compare_all();
      logic [31:0] v;
      for (int n = 0; n < NC; n++) begin
         rd(8'('h20 + 4 * n), v);
         chk(cur_req, $sformatf("model count%0d", n), v, m_cnt[n]);
         rd(8'(4 * n), v);
         chk(cur_req, $sformatf("model ctrl%0d", n), v,
             {m_sel[n], m_pre[n], 13'b0, m_en[n], 1'b0, m_ovf[n]});
      end
      chk(cur_req, "model irq", irq, m_ovf[0]);
   endtask

   task automatic tick();
      model_step();
      @(posedge clk);
      @(negedge clk);
      compare_all();
   endtask

   task automatic ticks(input int k);
      for (int i = 0; i < k; i++) tick();
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
      tick();
      reg_wen = 1'b0;
   endtask

   task automatic rbeat(input logic [15:0] id, input logic [2:0] p, input logic c);
      rd_beat = 1; rd_id = id; rd_port = p; rd_chan = c;
      tick();
      rd_beat = 0;
   endtask

   task automatic wbeat(input logic [15:0] id, input logic [2:0] p, input logic c);
      wr_beat = 1; wr_id = id; wr_port = p; wr_chan = c;
      tick();
      wr_beat = 0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] v, a0, a2, a3;
      for (int n = 0; n < NC; n++) begin
         m_cnt[n] = 0; m_en[n] = 0; m_ovf[n] = 0; m_pre[n] = 0;
         m_sel[n] = 0; m_flt[n] = 0; m_selw[n] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      cur_req = "R1";
      for (int n = 0; n < NC; n++) begin
         rd(8'(4 * n), v);        chk("R1", "ctrl after reset", v, 0);
         rd(8'('h20 + 4 * n), v); chk("R1", "count after reset", v, 0);
      end
      chk("R1", "irq after reset", irq, 0);

      // R2 enable+clear with preload
      cur_req = "R2";
      wr(8'h04, 32'h0105_0006);
      rd(8'h04, v); chk("R2", "ctrl1 readback", v, 32'h0105_0004);
      rd(8'h24, v); chk("R2", "count1 preload", v, 32'h050);

      // R4 bank idle while slot 0 disabled
      cur_req = "R4";
      evt = 8'h01;
      ticks(4);
      evt = '0;
      rd(8'h24, v); chk("R4", "count1 held while idle", v, 32'h050);

      // R3 cycle counting
      cur_req = "R3";
      wr(8'h00, 32'h0000_0006);
      ticks(5);
      rd(8'h20, v); chk("R3", "count0 after 5 clocks", v, 5);

      // R8 generic events
      cur_req = "R8";
      evt = 8'h01;
      ticks(3);
      evt = '0;
      rd(8'h24, v); chk("R8", "count1 after 3 pulses", v, 32'h053);
      wr(8'h08, 32'h7F00_0006);
      evt = '1;
      ticks(3);
      evt = '0;
      rd(8'h28, v); chk("R8", "unknown code counts nothing", v, 0);

      // R9 read-beat filter
      cur_req = "R9";
      wr(8'h64, 32'h00FF_1234);
      wr(8'h60, 32'h0000_0003);
      wr(8'h08, 32'h4100_0006);
      rd(8'h64, v); chk("R9", "filter word readback", v, 32'h00FF_1234);
      rbeat(16'h12AB, 3'd3, 1'b1);
      rbeat(16'h13AB, 3'd3, 1'b1);
      rbeat(16'h1200, 3'd2, 1'b1);
      rbeat(16'h12FF, 3'd3, 1'b0);
      wbeat(16'h1234, 3'd3, 1'b1);
      rbeat(16'h1234, 3'd3, 1'b1);
      rd(8'h28, v); chk("R9", "read-beat matches", v, 2);

      // R10 write-beat filter
      cur_req = "R10";
      wr(8'h70, 32'h0000_0D00);
      wr(8'h74, 32'hFFFF_0000);
      wr(8'h0C, 32'h4200_0006);
      wbeat(16'hBEEF, 3'd5, 1'b0);
      wbeat(16'h0001, 3'd5, 1'b0);
      wbeat(16'h7777, 3'd5, 1'b1);
      wbeat(16'h7777, 3'd4, 1'b0);
      rbeat(16'h7777, 3'd5, 1'b0);
      wbeat(16'h4242, 3'd5, 1'b0);
      rd(8'h2C, v); chk("R10", "write-beat matches", v, 3);

      // R6 non-cycle slot overflow
      cur_req = "R6";
      wr(8'h04, 32'h01FF_0006);
      rd(8'h20, a0);
      evt = 8'h01;
      ticks(20);
      evt = '0;
      rd(8'h04, v); chk("R6", "slot1 overflow flag", v[0], 1);
      rd(8'h24, v); chk("R6", "slot1 parked at zero", v, 0);
      chk("R6", "no irq on slot1 overflow", irq, 0);
      rd(8'h20, v); chk("R6", "slot0 kept counting", v, a0 + 20);

      // R5 cycle slot overflow freezes bank
      cur_req = "R5";
      wr(8'h00, 32'h00FF_0006);
      ticks(20);
      chk("R5", "irq raised", irq, 1);
      rd(8'h20, v); chk("R5", "count0 wrapped", v, 0);
      rd(8'h00, v); chk("R5", "ctrl0 overflow flag", v[0], 1);
      rd(8'h28, a2); rd(8'h2C, a3);
      for (int i = 0; i < 5; i++) begin
         rd_beat = 1; rd_id = 16'h1234; rd_port = 3; rd_chan = 1;
         wr_beat = 1; wr_id = 16'h0; wr_port = 5; wr_chan = 0;
         tick();
      end
      rd_beat = 0; wr_beat = 0;
      rd(8'h28, v); chk("R5", "slot2 frozen", v, a2);
      rd(8'h2C, v); chk("R5", "slot3 frozen", v, a3);

      // R7 clear flag restarts bank
      cur_req = "R7";
      wr(8'h00, 32'h0000_0005);
      chk("R7", "irq dropped", irq, 0);
      ticks(3);
      rd(8'h20, v); chk("R7", "count0 resumed", v, 3);

      // mixed traffic against the model
      cur_req = "R8";
      wr(8'h04, 32'h0300_0006);
      for (int i = 0; i < 3000; i++) begin
         evt     = NG'($urandom);
         rd_beat = 1'($urandom); rd_id = {8'h12, 8'($urandom)};
         rd_port = 3'($urandom_range(2, 3)); rd_chan = 1'($urandom);
         wr_beat = 1'($urandom); wr_id = 16'($urandom);
         wr_port = 3'($urandom_range(4, 5)); wr_chan = 1'($urandom);
         if (i % 250 == 249) wr(8'h00, 32'h0000_0005);
         else tick();
      end
      evt = '0; rd_beat = 0; wr_beat = 0;
      tick();

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule